// File: doc/BRIEF.md
# Digital Timebase Calibrator

This block trims a 32768 Hz oscillator timebase with no analog adjustment. It holds a two-stage prescaler. The first stage divides by 256 and the second divides by 128. At the boundary between the two stages it removes or adds oscillator counts. The output is a corrected one-second tick.

A timekeeper counts the ticks into minutes and returns a minute strobe. The block uses that strobe to track its position inside a repeating 64-minute schedule. In each eligible minute, the first second is changed once. With the sign bit at 1 that second is stretched by one full first-stage period. With the sign bit at 0 it is cut by half a first-stage period. A 5-bit magnitude N makes the first 2×N minutes of the schedule eligible, to a ceiling of 62 minutes. The two stage widths are parameters, so the same structure also runs at a reduced scale.

Top module: `osc_cal_trim`

## Requirements
- R1: Reset clears both prescaler stages, the schedule position and any pending correction. `sec_tick_o` stays low while `rst_ni` is low.
- R2: An uncorrected second lasts exactly 2^(PRE_W+POST_W) enabled oscillator cycles (32768 by default). `sec_tick_o` is high for one clock, in the clock that follows the enabled cycle that completes the second.
- R3: Only clocks with `osc_en_i` high advance the prescaler. Clocks with `osc_en_i` low change neither the count nor the tick timing.
- R4: When `cal_sign_i` was 1 at the minute strobe and the minute is eligible, the first second of that minute lasts 2^PRE_W cycles longer (+256 by default).
- R5: When `cal_sign_i` was 0 at the minute strobe and the minute is eligible, the first second of that minute lasts 2^(PRE_W-1) cycles shorter (−128 by default).
- R6: The first `min_tick_i` after reset starts minute 0 of the schedule. Each later strobe starts the next minute, and the count wraps from 63 to 0.
- R7: Minute k is eligible when k < min(2×`cal_mag_i`, 62). Minutes 62 and 63 are never eligible, even with a magnitude of 31.
- R8: A magnitude of 0 leaves every second at its nominal length.
- R9: In a corrected minute only the first second changes. Every other second keeps its nominal length.
- R10: `cal_mag_i` and `cal_sign_i` are sampled only on the clock where `min_tick_i` is high. A change between strobes does not affect the second in progress and first applies to the next minute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | Clock enable, high for one clock per oscillator cycle |
| min_tick_i | input | 1 | Minute strobe from the timekeeper; must arrive before the final first-stage period of the first second of the minute |
| cal_mag_i | input | 5 | Correction magnitude N (0 to 31) |
| cal_sign_i | input | 1 | 1 = stretch the affected second, 0 = shorten it |
| sec_tick_o | output | 1 | Corrected one-second pulse |

## Verification
The tick is registered. It is therefore due one clock after the posedge at which the enabled cycle that closes a second is counted. The bench's behavioural model raises its expected tick at that same edge and compares it with `sec_tick_o` on the following falling edge.

A minute strobe is sampled on the edge where it is high. Its correction shows up only at the end of the second already in progress, at most one second plus one clock later. The model therefore assigns the latched adjustment to that open second rather than to the next one.

Second lengths are captured on the edge after each tick. Per-schedule counts are read on a falling edge after that capture, so every window holds exactly two seconds per minute.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;

  localparam int CAL_MAG_W   = 5;
  localparam int CYC_IDX_W   = 6;              // 64-minute schedule
  localparam int CYC_WIN_W   = CYC_IDX_W + 1;
  localparam int CYC_MAX_ADJ = 62;

  typedef struct packed {
    logic                 sign;
    logic [CAL_MAG_W-1:0] mag;
  } cal_cfg_t;

  // number of eligible minutes: 2*mag, capped
  function automatic logic [CYC_WIN_W-1:0] win_len(input logic [CAL_MAG_W-1:0] mag);
    logic [CYC_WIN_W-1:0] dbl;
    dbl = CYC_WIN_W'({mag, 1'b0});
    return (dbl > CYC_WIN_W'(CYC_MAX_ADJ)) ? CYC_WIN_W'(CYC_MAX_ADJ) : dbl;
  endfunction

endpackage

// File: rtl/osc_cal_prescale.sv
module osc_cal_prescale #(
  parameter int PRE_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  logic short_i,
  output logic carry_o
);

  localparam logic [PRE_W-1:0] PRE_FULL = '1;
  localparam logic [PRE_W-1:0] PRE_HALF = PRE_FULL >> 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_last;
  logic             carry;

  assign pre_last = short_i ? PRE_HALF : PRE_FULL;
  assign carry    = osc_en_i && (pre_q == pre_last);
  assign carry_o  = carry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (osc_en_i) begin
      pre_q <= carry ? '0 : pre_q + PRE_W'(1);
    end
  end

  AST_SHORT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_i |-> (pre_q <= PRE_HALF)); // R5
  AST_PRE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> $stable(pre_q)); // R3

endmodule

// File: rtl/osc_cal_sec_div.sv
module osc_cal_sec_div #(
  parameter int POST_W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic carry_i,
  input  logic arm_i,
  input  logic sign_i,
  output logic short_o,
  output logic sec_end_o,
  output logic sec_tick_o
);

  localparam logic [POST_W-1:0] POST_TERM = '1;
  localparam logic [POST_W-1:0] POST_PEN  = POST_W'((1 << POST_W) - 2);

  logic [POST_W-1:0] post_q;
  logic              ext_q;
  logic              short_q;
  logic              tick_q;
  logic              at_term;
  logic              stretch;
  logic              sec_end;

  assign at_term = (post_q == POST_TERM);
  // positive correction: hold terminal count for one extra first-stage period
  assign stretch = arm_i && sign_i && !ext_q;
  assign sec_end = carry_i && at_term && !stretch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_q  <= '0;
      ext_q   <= 1'b0;
      short_q <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= sec_end;
      if (carry_i) begin
        if (at_term) begin
          if (stretch) begin
            ext_q <= 1'b1;
          end else begin
            post_q  <= '0;
            ext_q   <= 1'b0;
            short_q <= 1'b0;
          end
        end else begin
          post_q <= post_q + POST_W'(1);
          // negative correction: final first-stage period runs at half length
          if (post_q == POST_PEN) short_q <= arm_i && !sign_i;
        end
      end
    end
  end

  assign short_o    = short_q;
  assign sec_end_o  = sec_end;
  assign sec_tick_o = tick_q;

  AST_EXT_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q |-> at_term); // R4
  AST_EXT_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_q) |-> $past(arm_i && sign_i)); // R4
  AST_SHORT_NOT_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_q |-> !ext_q); // R5
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q); // R2

endmodule

// File: rtl/osc_cal_sched.sv
module osc_cal_sched
  import osc_cal_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     min_tick_i,
  input  cal_cfg_t cfg_i,
  input  logic     sec_end_i,
  output logic     arm_o,
  output logic     sign_o
);

  logic [CYC_IDX_W-1:0] next_idx_q;
  logic                 sign_q;
  logic                 arm_q;
  logic                 eligible;

  assign eligible = {1'b0, next_idx_q} < win_len(cfg_i.mag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_idx_q <= '0;
      sign_q     <= 1'b0;
      arm_q      <= 1'b0;
    end else if (min_tick_i) begin
      next_idx_q <= next_idx_q + CYC_IDX_W'(1);
      sign_q     <= cfg_i.sign;
      arm_q      <= eligible;
    end else if (sec_end_i) begin
      arm_q <= 1'b0;
    end
  end

  assign arm_o  = arm_q;
  assign sign_o = sign_q;

  AST_IDX_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_tick_i && (next_idx_q == '1)) |=> (next_idx_q == '0)); // R6
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !min_tick_i |=> $stable(next_idx_q)); // R6
  AST_ZERO_MAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_tick_i && (cfg_i.mag == '0)) |=> !arm_q); // R8
  AST_TAIL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_tick_i && (next_idx_q >= CYC_IDX_W'(CYC_MAX_ADJ))) |=> !arm_q); // R7
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !min_tick_i |=> $stable(sign_q)); // R10

endmodule

// File: rtl/osc_cal_trim.sv
module osc_cal_trim
  import osc_cal_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int POST_W = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 osc_en_i,
  input  logic                 min_tick_i,
  input  logic [CAL_MAG_W-1:0] cal_mag_i,
  input  logic                 cal_sign_i,
  output logic                 sec_tick_o
);

  cal_cfg_t cfg;
  logic     carry;
  logic     short_req;
  logic     sec_end;
  logic     arm;
  logic     sign;

  assign cfg = '{sign: cal_sign_i, mag: cal_mag_i};

  osc_cal_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_en_i (osc_en_i),
    .short_i  (short_req),
    .carry_o  (carry)
  );

  osc_cal_sec_div #(.POST_W(POST_W)) u_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .carry_i    (carry),
    .arm_i      (arm),
    .sign_i     (sign),
    .short_o    (short_req),
    .sec_end_o  (sec_end),
    .sec_tick_o (sec_tick_o)
  );

  osc_cal_sched u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .min_tick_i (min_tick_i),
    .cfg_i      (cfg),
    .sec_end_i  (sec_end),
    .arm_o      (arm),
    .sign_o     (sign)
  );

  AST_TICK_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_tick_o) |-> $past(osc_en_i)); // R3

  always_comb begin
    if (!rst_ni) AST_RESET_QUIET: assert (!sec_tick_o); // R1
  end

endmodule

// File: tb/osc_cal_trim_bench.sv
module osc_cal_trim_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PRE_W      = 3;
  localparam int POST_W     = 2;
  localparam int NOM        = 1 << (PRE_W + POST_W);
  localparam int LONG       = NOM + (1 << PRE_W);
  localparam int SHORT      = NOM - (1 << (PRE_W - 1));
  localparam int SPM        = 2;   // seconds per minute in the bench timekeeper

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_en_i = 1'b0;
  logic       min_tick_i = 1'b0;
  logic [4:0] cal_mag_i = '0;
  logic       cal_sign_i = 1'b0;
  logic       sec_tick_o;

  osc_cal_trim #(.PRE_W(PRE_W), .POST_W(POST_W)) u_osc_cal_trim (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .osc_en_i   (osc_en_i),
    .min_tick_i (min_tick_i),
    .cal_mag_i  (cal_mag_i),
    .cal_sign_i (cal_sign_i),
    .sec_tick_o (sec_tick_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R2";
  bit    running = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp_v,
                       input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  function automatic int win(input int mag);
    return (2 * mag > 62) ? 62 : 2 * mag;
  endfunction

  // timekeeper and oscillator enable, driven on falling edges
  bit       gaps = 1'b0;
  bit       mid_flag = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  int       sec_in_min = 0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      osc_en_i   = 1'b0;
      min_tick_i = 1'b0;
      mid_flag   = 1'b0;
    end else begin
      lfsr       = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      osc_en_i   = gaps ? (lfsr[0] | lfsr[2]) : 1'b1;
      min_tick_i = 1'b0;
      mid_flag   = 1'b0;
      if (sec_tick_o) begin
        if (sec_in_min == SPM - 1) begin
          min_tick_i = 1'b1;
          sec_in_min = 0;
        end else begin
          sec_in_min++;
          if (sec_in_min == 1) mid_flag = 1'b1;
        end
      end
    end
  end

  // reference model and length measurement, on rising edges
  int m_cnt, m_adj, m_idx, started;
  bit exp_tick;
  int meas, len_seq, last_len;
  int n_nom, n_long, n_short, n_oth;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cnt = 0; m_adj = 0; m_idx = 0; started = 0; exp_tick = 1'b0;
      meas = 0; len_seq = 0; last_len = 0;
    end else begin
      if (sec_tick_o) begin
        last_len = meas;
        len_seq++;
        if (meas == NOM) n_nom++;
        else if (meas == LONG) n_long++;
        else if (meas == SHORT) n_short++;
        else n_oth++;
        meas = int'(osc_en_i);
      end else begin
        meas += int'(osc_en_i);
      end
      exp_tick = 1'b0;
      if (min_tick_i) begin
        started = m_idx;
        m_adj   = (m_idx < win(int'(cal_mag_i))) ? (cal_sign_i ? LONG - NOM : SHORT - NOM) : 0;
        m_idx   = (m_idx + 1) % 64;
      end
      if (osc_en_i) begin
        m_cnt++;
        if (m_cnt == NOM + m_adj) begin
          exp_tick = 1'b1;
          m_cnt    = 0;
          m_adj    = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (running) check(sec_tick_o === exp_tick, cur_req, int'(sec_tick_o), int'(exp_tick),
                       "tick vs model");
  end

  task automatic wait_mid();
    do @(posedge clk); while (!mid_flag);
    @(negedge clk);
  endtask

  task automatic wait_len(input int target);
    do @(posedge clk); while (len_seq < target);
    @(negedge clk);
  endtask

  task automatic run_phase(input int mag, input bit sgn, input bit gp, input int nmin,
                           input string req, input int exp_long, input int exp_short);
    int b_nom, b_long, b_short, b_oth;
    wait_mid();
    cal_mag_i  = 5'(mag);
    cal_sign_i = sgn;
    gaps       = gp;
    cur_req    = req;
    b_nom = n_nom; b_long = n_long; b_short = n_short; b_oth = n_oth;
    repeat (nmin) wait_mid();
    check(n_long - b_long == exp_long, req, n_long - b_long, exp_long, "stretched seconds");
    check(n_short - b_short == exp_short, req, n_short - b_short, exp_short, "shortened seconds");
    // R9: every other second stays nominal
    check(n_nom - b_nom == SPM * nmin - exp_long - exp_short, "R9", n_nom - b_nom,
          SPM * nmin - exp_long - exp_short, "nominal seconds");
    check(n_oth == b_oth, req, n_oth - b_oth, 0, "odd-length seconds");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int s;
    repeat (4) begin
      @(negedge clk);
      check(sec_tick_o == 1'b0, "R1", int'(sec_tick_o), 0, "tick in reset");
    end
    rst_ni = 1'b1;
    running = 1'b1;
    wait_len(1);
    check(last_len == NOM, "R2", last_len, NOM, "first second after reset");

    run_phase(0, 1'b1, 1'b0, 4, "R8", 0, 0);
    run_phase(3, 1'b1, 1'b0, 64, "R4", 6, 0);
    run_phase(5, 1'b0, 1'b0, 64, "R5", 0, 10);
    run_phase(1, 1'b1, 1'b0, 64, "R6", 2, 0);     // window starts mid-schedule, must wrap
    run_phase(31, 1'b1, 1'b1, 64, "R7", 62, 0);   // cap at 62 minutes
    run_phase(7, 1'b0, 1'b1, 64, "R3", 0, 14);    // sparse enables

    // R10: change inputs after the strobe, before the affected second ends
    wait_mid();
    cal_mag_i  = 5'd20;
    cal_sign_i = 1'b0;
    gaps       = 1'b0;
    cur_req    = "R10";
    do @(posedge clk); while (!min_tick_i);
    @(negedge clk);
    cal_mag_i  = 5'd0;
    cal_sign_i = 1'b1;
    s = len_seq;
    wait_len(s + 1);
    check(last_len == ((started < 40) ? SHORT : NOM), "R10", last_len,
          (started < 40) ? SHORT : NOM, "second after late change");
    wait_len(s + 3);
    check(last_len == NOM, "R10", last_len, NOM, "next minute uses new value");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule